// File: doc/BRIEF.md
# Asynchronous serial transmitter with held ninth bit

The block serialises bytes onto an asynchronous line. A data write captures the byte together with a separately stored ninth bit into a one-entry holding register. When the shifter is idle it takes that word and sends one start bit, the data bits LSB first, the ninth bit when nine-bit frames are selected, and one stop bit. Each bit lasts a number of clock cycles given by a plain divider input. The ninth-bit register keeps its value across data writes, so a fixed mark or space parity bit is written once and reused.

A polarity control inverts everything on the line: idle, start, data, stop and break levels. A break request sends a run of low bit times followed by a high bit. For a single shared wire, a direction control chooses between driving the pin and releasing it. Status outputs report when the holding register is free and when all transmission has finished.

Top module: `sertx_top`

## Requirements
- R1: After reset `tx_line` is 1, `tx_oe` is 1, `tx_empty` is 1 and `tx_done` is 1. All control bits are 0.
- R2: A frame is one start bit (0), the data bits LSB first, then one stop bit (1). Each bit lasts `baud_div` cycles. Between frames the line idles at 1. Levels are stated before any inversion.
- R3: When control bit 0 (nine-bit mode) is 1, the ninth bit follows data bit 7 and comes before the stop bit, giving 11 bit times per frame.
- R4: A write to address 0 (data) captures `{ninth register, wr_data}` at once. A later write to address 1 (ninth bit, `wr_data[0]`) does not change a word already captured. The ninth register keeps its value across data writes.
- R5: When control bit 1 (invert) is 1, `tx_line` is the complement of every level R2, R3 and R7 give, including idle. The setting takes effect live.
- R6: When control bit 2 (single wire) is 1, `tx_oe` equals control bit 3 (1 = drive, 0 = release). Otherwise `tx_oe` is 1.
- R7: Writing address 2 (control) with bit 4 set requests a break. The break is 10 low bit times (11 in nine-bit mode) followed by one high bit. A pending break is sent before a pending data word.
- R8: `tx_empty` goes low in the cycle after a data write is sampled. It returns high in the cycle after the shifter takes the word.
- R9: `tx_done` is high only when no frame is being sent and nothing is pending. It drops in the cycle after a data write is sampled. It rises in the cycle after the last stop-bit cycle.
- R10: When the transmitter is idle, the start bit appears on the line from the clock edge that follows the edge that samples the data write.
- R11: A `baud_div` of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 ninth bit, 2 control |
| wr_data | input | DATA_W | Write value |
| baud_div | input | DIV_W | Clock cycles per bit |
| tx_line | output | 1 | Serial line level after polarity |
| tx_oe | output | 1 | Pin drive enable |
| tx_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Nothing sent and nothing pending |

## Verification
A data write sampled at edge E drops `tx_empty` and `tx_done` at the next falling edge. The start bit and the return of `tx_empty` follow one cycle later. The bench checks both states at exactly those falling edges. Each bit k of a frame then covers cycles k·div to k·div+div−1 from the first start cycle, so the decoder samples at k·div+div/2. `tx_done` is checked low on the last stop cycle and high one cycle later. Register and output-enable changes are checked at the falling edge right after the write.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_DATA  = 2'd0,
        ADR_NINTH = 2'd1,
        ADR_CTRL  = 2'd2
    } reg_addr_e;

    // control word bit positions
    localparam int CB_NINE   = 0;
    localparam int CB_INV    = 1;
    localparam int CB_SINGLE = 2;
    localparam int CB_DIR    = 3;
    localparam int CB_BRK    = 4;

    typedef struct packed {
        logic nine;
        logic inv;
        logic single;
        logic dir;
    } ctrl_t;

endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    take_data,
    input  logic                    take_brk,
    output ctrl_t                   ctrl,
    output logic [DATA_W:0]         hold_word,
    output logic                    hold_full,
    output logic                    brk_pend
);

    typedef struct packed {
        ctrl_t           ctrl;
        logic            ninth;
        logic [DATA_W:0] hold;
        logic            full;
        logic            brk;
    } reg_st_t;

    reg_st_t q, d;
    logic wr_dat, wr_nin, wr_ctl;

    always_comb begin
        wr_dat = wr_en && (wr_addr == ADR_DATA);
        wr_nin = wr_en && (wr_addr == ADR_NINTH);
        wr_ctl = wr_en && (wr_addr == ADR_CTRL);
        d = q;
        if (take_data) d.full = 1'b0;
        if (take_brk)  d.brk  = 1'b0;
        if (wr_dat) begin
            d.hold = {q.ninth, wr_data};
            d.full = 1'b1;
        end
        if (wr_nin) d.ninth = wr_data[0];
        if (wr_ctl) begin
            d.ctrl.nine   = wr_data[CB_NINE];
            d.ctrl.inv    = wr_data[CB_INV];
            d.ctrl.single = wr_data[CB_SINGLE];
            d.ctrl.dir    = wr_data[CB_DIR];
            if (wr_data[CB_BRK]) d.brk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl      = q.ctrl;
    assign hold_word = q.hold;
    assign hold_full = q.full;
    assign brk_pend  = q.brk;

    p_write_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_DATA) |=> hold_full);

    p_take_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_data && !(wr_en && wr_addr == ADR_DATA)) |=> !hold_full);

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] last;

    always_comb begin
        last  = (div == '0) ? '0 : div - 1'b1;
        tick  = (cnt_q >= last);
        cnt_d = (restart || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_tick_wraps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nine,
    input  logic [DATA_W:0] hold_word,
    input  logic            hold_full,
    input  logic            brk_pend,
    input  logic            tick,
    output logic            take_data,
    output logic            take_brk,
    output logic            restart,
    output logic            busy,
    output logic            line_raw
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int LEFT_W  = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] frame;
        logic [LEFT_W-1:0]  left;
    } sh_st_t;

    sh_st_t q, d;
    int low_cnt;

    always_comb begin
        take_brk  = !q.busy && brk_pend;
        take_data = !q.busy && !brk_pend && hold_full;
        restart   = take_brk || take_data;
        low_cnt   = nine ? DATA_W + 3 : DATA_W + 2;
        d = q;
        if (take_brk) begin
            for (int i = 0; i < FRAME_W; i++)
                d.frame[i] = (i >= low_cnt);
            d.left = LEFT_W'(low_cnt + 1);
            d.busy = 1'b1;
        end else if (take_data) begin
            d.frame    = '1;
            d.frame[0] = 1'b0;
            for (int i = 0; i < DATA_W; i++)
                d.frame[i+1] = hold_word[i];
            if (nine) d.frame[DATA_W+1] = hold_word[DATA_W];
            d.left = nine ? LEFT_W'(DATA_W + 3) : LEFT_W'(DATA_W + 2);
            d.busy = 1'b1;
        end else if (q.busy && tick) begin
            d.frame = {1'b1, q.frame[FRAME_W-1:1]};
            d.left  = q.left - 1'b1;
            if (q.left == LEFT_W'(1)) d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.busy  <= 1'b0;
            q.frame <= '1;
            q.left  <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign line_raw = q.busy ? q.frame[0] : 1'b1;

    p_load_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.busy && (hold_full || brk_pend)) |=> q.busy);

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !line_raw);

    p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.left == LEFT_W'(1)) |-> line_raw);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  baud_div,
    output logic              tx_line,
    output logic              tx_oe,
    output logic              tx_empty,
    output logic              tx_done
);

    ctrl_t           ctrl;
    logic [DATA_W:0] hold_word;
    logic hold_full, brk_pend, take_data, take_brk, restart, tick, busy, line_raw;

    sertx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .take_data(take_data), .take_brk(take_brk),
        .ctrl(ctrl), .hold_word(hold_word), .hold_full(hold_full),
        .brk_pend(brk_pend)
    );

    sertx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(baud_div), .restart(restart), .tick(tick)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .nine(ctrl.nine), .hold_word(hold_word),
        .hold_full(hold_full), .brk_pend(brk_pend), .tick(tick),
        .take_data(take_data), .take_brk(take_brk), .restart(restart),
        .busy(busy), .line_raw(line_raw)
    );

    assign tx_line  = line_raw ^ ctrl.inv;
    assign tx_oe    = ctrl.single ? ctrl.dir : 1'b1;
    assign tx_empty = !hold_full;
    assign tx_done  = !busy && !hold_full && !brk_pend;

    p_done_means_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> tx_empty);

    p_write_drops_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_DATA) |=> !tx_done);

endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] baud_div = 16'd2;
    logic tx_line, tx_oe, tx_empty, tx_done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sertx_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .baud_div(baud_div), .tx_line(tx_line),
        .tx_oe(tx_oe), .tx_empty(tx_empty), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge, returns at the falling edge after the sampling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input bit nine, input bit inv, input bit single,
                                       input bit dir, input bit brk);
        return {3'b000, brk, dir, single, inv, nine};
    endfunction

    function automatic logic [15:0] exp_frame(input logic [7:0] d, input bit nine, input bit ninth);
        logic [15:0] f = '1;
        f[0] = 1'b0;
        f[8:1] = d;
        if (nine) f[9] = ninth;
        return f;
    endfunction

    // decode nb bit times (pre-inversion) starting at the first non-idle cycle
    task automatic rx(input int nb, input int div, input bit inv,
                      output logic [15:0] got, output int lat);
        int ed = (div == 0) ? 1 : div;
        int pos = 0;
        got = '1;
        lat = 0;
        while (tx_line == (1'b1 ^ inv) && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        for (int k = 0; k < nb; k++) begin
            int tgt = k * ed + ed / 2;
            repeat (tgt - pos) @(negedge clk);
            pos = tgt;
            got[k] = tx_line ^ inv;
        end
    endtask

    // finish the stop bit from its middle; check tx_done edge (R9)
    task automatic end_of_stop(input int div);
        int ed = (div == 0) ? 1 : div;
        repeat (ed - ed / 2 - 1) @(negedge clk);
        chk(tx_done == 1'b0, "R9 done low in stop", tx_done, 0);
        @(negedge clk);
        chk(tx_done == 1'b1, "R9 done after stop", tx_done, 1);
        chk(tx_line == (1'b1 ^ u_inv), "R5 idle level", tx_line, 1 ^ u_inv);
    endtask

    bit u_inv = 1'b0;

    task automatic send_one(input logic [7:0] d, input bit nine, input bit ninth,
                            input int div, input string req);
        logic [15:0] got, mask;
        int lat;
        int nb = nine ? 11 : 10;
        wr(2'd0, d);
        chk(tx_empty == 1'b0, "R8 empty low after write", tx_empty, 0);
        chk(tx_done == 1'b0, "R9 done low after write", tx_done, 0);
        rx(nb, div, u_inv, got, lat);
        chk(lat == 1, "R10 start latency", lat, 1);
        mask = 16'((1 << nb) - 1);
        chk((got & mask) == (exp_frame(d, nine, ninth) & mask), req,
            int'(got & mask), int'(exp_frame(d, nine, ninth) & mask));
        end_of_stop(div);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] got;
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_line == 1'b1, "R1 line", tx_line, 1);
        chk(tx_oe == 1'b1, "R1 oe", tx_oe, 1);
        chk(tx_empty == 1'b1, "R1 empty", tx_empty, 1);
        chk(tx_done == 1'b1, "R1 done", tx_done, 1);

        // R2 / R5: all bytes, 8-bit mode, both polarities
        baud_div = 16'd2;
        for (int inv = 0; inv < 2; inv++) begin
            u_inv = bit'(inv);
            wr(2'd2, ctl(0, bit'(inv), 0, 0, 0));
            chk(tx_line == (1'b1 ^ bit'(inv)), "R5 idle after ctrl", tx_line, 1 ^ inv);
            for (int d = 0; d < 256; d++)
                send_one(8'(d), 1'b0, 1'b0, 2, inv ? "R5 inverted 8-bit frame" : "R2 8-bit frame");
        end

        // R3 / R5: all bytes, nine-bit mode, both ninth values and polarities
        for (int inv = 0; inv < 2; inv++) begin
            u_inv = bit'(inv);
            wr(2'd2, ctl(1, bit'(inv), 0, 0, 0));
            for (int n = 0; n < 2; n++) begin
                wr(2'd1, 8'(n));
                for (int d = 0; d < 256; d++)
                    send_one(8'(d), 1'b1, bit'(n), 2, "R3 nine-bit frame");
            end
        end

        // R11: divider zero behaves as one; odd divider
        u_inv = 1'b0;
        wr(2'd2, ctl(0, 0, 0, 0, 0));
        baud_div = 16'd0;
        send_one(8'hA5, 1'b0, 1'b0, 1, "R11 div zero frame");
        send_one(8'h3C, 1'b0, 1'b0, 0, "R11 div zero frame");
        baud_div = 16'd3;
        send_one(8'h96, 1'b0, 1'b0, 3, "R2 div three frame");
        baud_div = 16'd4;

        // R4: ninth held across data writes
        wr(2'd2, ctl(1, 0, 0, 0, 0));
        wr(2'd1, 8'h01);
        send_one(8'h12, 1'b1, 1'b1, 4, "R4 ninth reused 1");
        send_one(8'h34, 1'b1, 1'b1, 4, "R4 ninth reused 2");

        // R4: word captured while busy keeps old ninth
        wr(2'd0, 8'h11);
        fork
            begin
                rx(11, 4, 1'b0, got, lat);
                chk((got & 16'h7FF) == (exp_frame(8'h11, 1, 1) & 16'h7FF), "R4 frame A",
                    int'(got & 16'h7FF), int'(exp_frame(8'h11, 1, 1) & 16'h7FF));
                rx(11, 4, 1'b0, got, lat);
                chk((got & 16'h7FF) == (exp_frame(8'h22, 1, 1) & 16'h7FF), "R4 captured ninth",
                    int'(got & 16'h7FF), int'(exp_frame(8'h22, 1, 1) & 16'h7FF));
            end
            begin
                repeat (5) @(negedge clk);
                wr(2'd0, 8'h22);
                chk(tx_empty == 1'b0, "R8 empty low while pending", tx_empty, 0);
                wr(2'd1, 8'h00);
            end
        join
        end_of_stop(4);
        send_one(8'h33, 1'b1, 1'b0, 4, "R4 new ninth used");

        // R7: break in 8-bit mode, inverted
        u_inv = 1'b1;
        wr(2'd2, ctl(0, 1, 0, 0, 1));
        rx(11, 4, 1'b1, got, lat);
        chk((got & 16'h7FF) == 16'h400, "R7 break 8-bit inverted", int'(got & 16'h7FF), 'h400);
        end_of_stop(4);

        // R7: break in nine-bit mode
        u_inv = 1'b0;
        wr(2'd2, ctl(1, 0, 0, 0, 1));
        rx(12, 4, 1'b0, got, lat);
        chk((got & 16'hFFF) == 16'h800, "R7 break nine-bit", int'(got & 16'hFFF), 'h800);
        end_of_stop(4);

        // R7: pending break precedes pending data
        wr(2'd2, ctl(0, 0, 0, 0, 0));
        wr(2'd0, 8'h55);
        fork
            begin
                rx(10, 4, 1'b0, got, lat);
                chk((got & 16'h3FF) == (exp_frame(8'h55, 0, 0) & 16'h3FF), "R2 frame before break",
                    int'(got & 16'h3FF), int'(exp_frame(8'h55, 0, 0) & 16'h3FF));
                rx(11, 4, 1'b0, got, lat);
                chk((got & 16'h7FF) == 16'h400, "R7 break first", int'(got & 16'h7FF), 'h400);
                rx(10, 4, 1'b0, got, lat);
                chk((got & 16'h3FF) == (exp_frame(8'hC3, 0, 0) & 16'h3FF), "R7 data after break",
                    int'(got & 16'h3FF), int'(exp_frame(8'hC3, 0, 0) & 16'h3FF));
            end
            begin
                repeat (5) @(negedge clk);
                wr(2'd0, 8'hC3);
                wr(2'd2, ctl(0, 0, 0, 0, 1));
            end
        join
        end_of_stop(4);

        // R6: output enable
        wr(2'd2, ctl(0, 0, 1, 0, 0));
        chk(tx_oe == 1'b0, "R6 single wire release", tx_oe, 0);
        wr(2'd2, ctl(0, 0, 1, 1, 0));
        chk(tx_oe == 1'b1, "R6 single wire drive", tx_oe, 1);
        wr(2'd2, ctl(0, 0, 0, 0, 0));
        chk(tx_oe == 1'b1, "R6 dual wire", tx_oe, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule